// File: doc/BRIEF.md
# Overrange Flag Timeout and Serial Multiplexer

This block watches overrange pulses from the two channels of a stereo audio converter and turns them into one active-low status line. Each channel has a held flag. A pulse on a channel sets that channel's flag at once. Any pulse, on either channel, restarts one shared timeout. When the timeout runs out with no new pulse, both flags drop.

The timeout is measured in audio frames, which are counted on rising edges of the frame clock. The base count is `2**TMO_LOG2` frames (2^15 by default). It doubles in double-speed mode and quadruples in quad-speed mode. Because of this scaling, the wall-clock time is the same in every speed mode: about 743 ms at the 44.1 kHz family rates and about 683 ms at the 48 kHz family rates. No separate rate-family input is needed.

The two flags share one output line, switched in step with the frame clock. The line takes a new value a fixed number of bit-clock falling edges after each frame-clock edge. A receiver recovers the two flags by sampling the line on the frame-clock edges. The frame clock and bit clock are sampled in the system clock domain, so both must be much slower than `clk`. The output can drive an open-drain pad directly.

Top module: `ovr_flag_mux`

## Requirements
- R1: After reset `ovfl_n` is 1, both flags are clear and the timeout counter is zero.
- R2: A one-cycle pulse on `ovr_left` or `ovr_right` sets that channel's held flag on the next `clk` edge. The line shows the flag as 0 at that channel's next line update.
- R3: Held flags clear together after N rising `lrck` edges with no pulse. N = 2**TMO_LOG2 × M, where M depends on `speed`: 00 gives ×1, 01 gives ×2, 10 gives ×4, and the reserved code 11 gives ×4.
- R4: A pulse on either channel restarts the timeout count from zero for both flags.
- R5: A pulse that lands in the same `clk` cycle as the expiring `lrck` rising edge wins. The held flags stay set and the count restarts.
- R6: With `fmt_i2s`=0, the line is updated on the 1st `sclk` falling edge after an `lrck` edge. During `lrck`=1 it carries the left flag, and during `lrck`=0 the right flag.
- R7: With `fmt_i2s`=1, the line is updated on the 2nd `sclk` falling edge after an `lrck` edge. During `lrck`=1 it carries the right flag, and during `lrck`=0 the left flag.
- R8: A channel whose flag is not held is shown as 1 on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all other inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ovr_left | input | 1 | Overrange pulse, left channel |
| ovr_right | input | 1 | Overrange pulse, right channel |
| lrck | input | 1 | Frame (left/right) clock level |
| sclk | input | 1 | Serial bit clock level |
| fmt_i2s | input | 1 | 0 = left-justified placement, 1 = I2S placement |
| speed | input | 2 | Speed code: 00 base, 01 double, 10 quad, 11 reserved (quad) |
| ovfl_n | output | 1 | Multiplexed active-low overrange line |

## Verification
A pulse reaches its held flag one `clk` cycle after it is sampled. An `sclk` falling edge that is due to move the line changes `ovfl_n` one `clk` cycle after the fall is sampled. The bench drives one `sclk` phase every 4 `clk` cycles and checks at the following `clk` falling edge. For each half-frame it checks the line twice: just after the 1st and 2nd `sclk` falls, to tell the left-justified offset from the I2S offset, and again at the end of the half. Pulses are injected in the middle of a half-frame, after that half's update, so the expected value for each half is the flag state captured at its opening edge. The priority case instead places the pulse in the exact cycle of the expiring `lrck` rise.

// File: rtl/ovr_flag_pkg.sv
package ovr_flag_pkg;

  typedef enum logic [1:0] {
    SPD_BASE   = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  // log2 of the frame multiplier for each speed code; reserved acts as quad
  function automatic logic [1:0] speed_shift(input speed_e s);
    case (s)
      SPD_BASE:   speed_shift = 2'd0;
      SPD_DOUBLE: speed_shift = 2'd1;
      default:    speed_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/ovr_rst_sync.sv
module ovr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/ovr_edge_det.sv
module ovr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck,
  input  logic sclk,
  output logic lrck_rise,
  output logic lrck_edge,
  output logic sclk_fall
);
  logic lrck_q, sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      lrck_q <= lrck;
      sclk_q <= sclk;
    end
  end

  assign lrck_rise = lrck & ~lrck_q;
  assign lrck_edge = lrck ^ lrck_q;
  assign sclk_fall = ~sclk & sclk_q;
endmodule

// File: rtl/ovr_timeout.sv
module ovr_timeout
  import ovr_flag_pkg::*;
#(
  parameter int TMO_LOG2 = 15
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ovr_l,
  input  logic   ovr_r,
  input  logic   tick,
  input  speed_e speed,
  output logic   held_l,
  output logic   held_r
);
  localparam int CW = TMO_LOG2 + 3;
  localparam logic [CW-1:0] BASE_LIM = CW'(1) << TMO_LOG2;

  logic [CW-1:0] cnt, cnt_n, lim;
  logic          held_l_n, held_r_n, any_ovr, expire;

  always_comb begin
    lim      = BASE_LIM << speed_shift(speed);
    any_ovr  = ovr_l | ovr_r;
    expire   = (cnt >= lim - CW'(1));
    held_l_n = held_l | ovr_l;
    held_r_n = held_r | ovr_r;
    cnt_n    = cnt;
    if (any_ovr) begin
      cnt_n = '0;
    end else if ((held_l | held_r) && tick) begin
      if (expire) begin
        cnt_n    = '0;
        held_l_n = 1'b0;
        held_r_n = 1'b0;
      end else begin
        cnt_n = cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      held_l <= 1'b0;
      held_r <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      held_l <= held_l_n;
      held_r <= held_r_n;
    end
  end

  a_r2_left_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_l |=> held_l);
  a_r2_right_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_r |=> held_r);
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_l || ovr_r) |=> (cnt == '0));
  a_r5_keep_left: assert property (@(posedge clk) disable iff (!rst_n)
    (held_l && ovr_r) |=> held_l);
  a_r3_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_l) |-> ($past(tick) && !$past(ovr_l || ovr_r)));
  a_r1_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    !(held_l || held_r) |-> (cnt == '0));
endmodule

// File: rtl/ovr_serializer.sv
module ovr_serializer (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck,
  input  logic lrck_edge,
  input  logic sclk_fall,
  input  logic fmt_i2s,
  input  logic held_l,
  input  logic held_r,
  output logic pin_n
);
  logic [1:0] pend, pend_n;
  logic       side_l, side_l_n, pin_n_n;

  always_comb begin
    pend_n   = pend;
    side_l_n = side_l;
    pin_n_n  = pin_n;
    if (lrck_edge) begin
      pend_n   = fmt_i2s ? 2'd2 : 2'd1;
      side_l_n = lrck ^ fmt_i2s;
    end else if (sclk_fall && (pend != 2'd0)) begin
      pend_n = pend - 2'd1;
      if (pend == 2'd1) pin_n_n = ~(side_l ? held_l : held_r);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 2'd0;
      side_l <= 1'b0;
      pin_n  <= 1'b1;
    end else begin
      pend   <= pend_n;
      side_l <= side_l_n;
      pin_n  <= pin_n_n;
    end
  end

  a_r6_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_n != $past(pin_n)) |-> ($past(sclk_fall) && !$past(lrck_edge)));
  a_r7_two_fall_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (lrck_edge && fmt_i2s) |=> (pend == 2'd2));
  a_r8_clear_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_l && !held_r && sclk_fall && pend == 2'd1 && !lrck_edge) |=> pin_n);
endmodule

// File: rtl/ovr_flag_mux.sv
module ovr_flag_mux
  import ovr_flag_pkg::*;
#(
  parameter int TMO_LOG2 = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovr_left,
  input  logic       ovr_right,
  input  logic       lrck,
  input  logic       sclk,
  input  logic       fmt_i2s,
  input  logic [1:0] speed,
  output logic       ovfl_n
);
  logic rst_s, lrck_rise, lrck_edge, sclk_fall, held_l, held_r;

  ovr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  ovr_edge_det u_edge (
    .clk(clk), .rst_n(rst_s), .lrck(lrck), .sclk(sclk),
    .lrck_rise(lrck_rise), .lrck_edge(lrck_edge), .sclk_fall(sclk_fall)
  );

  ovr_timeout #(.TMO_LOG2(TMO_LOG2)) u_tmo (
    .clk(clk), .rst_n(rst_s), .ovr_l(ovr_left), .ovr_r(ovr_right),
    .tick(lrck_rise), .speed(speed_e'(speed)),
    .held_l(held_l), .held_r(held_r)
  );

  ovr_serializer u_ser (
    .clk(clk), .rst_n(rst_s), .lrck(lrck), .lrck_edge(lrck_edge),
    .sclk_fall(sclk_fall), .fmt_i2s(fmt_i2s),
    .held_l(held_l), .held_r(held_r), .pin_n(ovfl_n)
  );

  a_r1_reset_high: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(rst_s) |-> ovfl_n);
endmodule

// File: tb/test_ovr_flag_mux.sv
module test_ovr_flag_mux;
  localparam int TL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovr_left = 1'b0, ovr_right = 1'b0, lrck = 1'b0, sclk = 1'b0, fmt_i2s = 1'b0;
  logic [1:0] speed = 2'b00;
  logic ovfl_n;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R2";

  // bench model of held flags
  bit m_l = 0, m_r = 0;
  int m_cnt = 0;
  logic exp_pin = 1'b1;

  always #2 clk = ~clk;

  ovr_flag_mux #(.TMO_LOG2(TL)) i_ovr_flag_mux (
    .clk(clk), .rst_n(rst_n), .ovr_left(ovr_left), .ovr_right(ovr_right),
    .lrck(lrck), .sclk(sclk), .fmt_i2s(fmt_i2s), .speed(speed), .ovfl_n(ovfl_n)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: ovfl_n=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int limit_frames();
    int sh = (speed == 2'b00) ? 0 : (speed == 2'b01) ? 1 : 2;
    return (1 << TL) << sh;
  endfunction

  // one half frame: 16 sclk periods of 8 clk cycles
  task automatic half(input logic lvl, input bit inj_l, input bit inj_r, input bit at_edge);
    logic old_exp, new_exp, sel_l;
    bit rise;
    string otag;
    old_exp = exp_pin;
    new_exp = exp_pin;
    otag = fmt_i2s ? "R7" : "R6";
    for (int b = 0; b < 16; b++) begin
      @(negedge clk);
      sclk = 1'b0;
      if (b == 0) begin
        rise = lvl && !lrck;
        lrck = lvl;
        if (at_edge && (inj_l || inj_r)) begin
          ovr_left = inj_l; ovr_right = inj_r;
          m_l = m_l | inj_l; m_r = m_r | inj_r; m_cnt = 0;
        end else if (rise && (m_l || m_r)) begin
          m_cnt++;
          if (m_cnt >= limit_frames()) begin m_l = 0; m_r = 0; m_cnt = 0; end
        end
        sel_l = lvl ^ fmt_i2s;
        new_exp = ~(sel_l ? m_l : m_r);
        exp_pin = new_exp;
      end
      @(negedge clk);
      ovr_left = 1'b0; ovr_right = 1'b0;
      if (b == 8 && !at_edge && (inj_l || inj_r)) begin
        ovr_left = inj_l; ovr_right = inj_r;
        m_l = m_l | inj_l; m_r = m_r | inj_r; m_cnt = 0;
      end
      @(negedge clk);
      ovr_left = 1'b0; ovr_right = 1'b0;
      if (b == 1) check(otag, ovfl_n, fmt_i2s ? old_exp : new_exp);
      if (b == 2) check(otag, ovfl_n, new_exp);
      @(negedge clk);
      @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
    end
    check(cur_tag, ovfl_n, new_exp);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      half(1'b1, 0, 0, 0);
      half(1'b0, 0, 0, 0);
    end
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check("R1", ovfl_n, 1'b1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", ovfl_n, 1'b1);
    cur_tag = "R8";
    frames(1);
  endtask

  task automatic t_lj_left();
    fmt_i2s = 1'b0; speed = 2'b00; cur_tag = "R2";
    half(1'b1, 0, 0, 0);
    half(1'b0, 1, 0, 0);
    cur_tag = "R6";
    frames(6);
  endtask

  task automatic t_i2s_right();
    fmt_i2s = 1'b1; speed = 2'b00; cur_tag = "R7";
    frames(1);
    half(1'b1, 0, 1, 0);
    half(1'b0, 0, 0, 0);
    frames(6);
  endtask

  task automatic t_restart();
    fmt_i2s = 1'b0; cur_tag = "R4";
    half(1'b1, 1, 0, 0);
    half(1'b0, 0, 0, 0);
    frames(2);
    half(1'b1, 0, 1, 0);
    half(1'b0, 0, 0, 0);
    frames(6);
  endtask

  task automatic t_speed(input logic [1:0] s);
    speed = s; cur_tag = "R3";
    half(1'b1, 0, 0, 0);
    half(1'b0, 1, 1, 0);
    frames(limit_frames() + 2);
  endtask

  task automatic t_priority();
    speed = 2'b00; fmt_i2s = 1'b1; cur_tag = "R5";
    half(1'b1, 1, 0, 0);
    half(1'b0, 0, 0, 0);
    frames(3);
    half(1'b1, 0, 1, 1);
    half(1'b0, 0, 0, 0);
    check("R5", ovfl_n, 1'b0);
    frames(6);
    check("R5", ovfl_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_lj_left();
    t_i2s_right();
    t_restart();
    t_speed(2'b01);
    t_speed(2'b10);
    t_speed(2'b11);
    t_priority();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule